// File: doc/BRIEF.md
# ALU with Registered Status Flags

This block is the arithmetic-logic stage of a small processor datapath. Each cycle it takes two 8-bit operands and a 3-bit opcode and produces a result on a combinational path. One ripple-carry adder serves plain addition, addition with the stored carry, and subtraction. For subtraction the adder sees operand B inverted and a carry-in of 1. Bitwise AND, OR and XOR units run alongside the adder, and a multiplexer picks the result that the opcode names.

Five status bits come from the same cycle's result and carries: carry, zero, negative, signed overflow and half-carry. They are captured on the rising clock edge only when the flag-write enable is high and the opcode is a defined one. The surrounding pipeline reads them on the next cycle, either for add-with-carry or for branch decisions elsewhere.

Top module: `alu_flag_unit`

## Requirements
- R1: Opcode 3'b000 (add) drives `result` = (opA + opB) mod 256 in the same cycle, with an adder carry-in of 0.
- R2: Opcode 3'b001 (add with carry) drives `result` = (opA + opB + C) mod 256, where C is the stored carry flag.
- R3: Opcode 3'b010 (subtract) drives `result` = (opA - opB) mod 256, formed as opA + ~opB + 1. The resulting carry flag is 1 when no borrow occurs (opA >= opB unsigned).
- R4: Opcodes 3'b011, 3'b100 and 3'b101 drive `result` to the bitwise AND, OR and XOR of the operands.
- R5: Opcodes 3'b110 and 3'b111 drive `result` to zero and leave all five flags unchanged, even while `flagWe` is 1.
- R6: After an arithmetic op written with `flagWe`=1, `flagC` equals the carry out of bit 7.
- R7: After any defined op written with `flagWe`=1, `flagZ` is 1 exactly when the result was all zero, and `flagN` equals result bit 7.
- R8: After an arithmetic op written with `flagWe`=1, `flagV` equals the carry out of bit 6 XOR the carry out of bit 7. This is signed overflow and differs from the carry flag.
- R9: After an arithmetic op written with `flagWe`=1, `flagH` equals the carry out of bit 3.
- R10: After a bitwise op written with `flagWe`=1, `flagV` is 0 while `flagC` and `flagH` keep their previous values.
- R11: Flags change only on a rising clock edge with `flagWe`=1. With `flagWe`=0 they hold, although `result` still follows the inputs.
- R12: While `rstN` is low at a rising edge, all five flags are cleared (synchronous, active low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous active-low reset of the flags |
| opA | input | 8 | Operand A |
| opB | input | 8 | Operand B |
| opcode | input | 3 | Operation select (encoding in R1 to R5) |
| flagWe | input | 1 | Flag-write enable for this cycle |
| result | output | 8 | Combinational result |
| flagC | output | 1 | Stored carry flag |
| flagZ | output | 1 | Stored zero flag |
| flagN | output | 1 | Stored negative flag |
| flagV | output | 1 | Stored signed-overflow flag |
| flagH | output | 1 | Stored half-carry flag |

## Verification
The bench uses vectors that separate carry from overflow. 0x7F+0x01 overflows without carry, and 0x80+0x80 carries and overflows to zero, so a design that reported carry-out as overflow fails on both. Nibble-boundary sums such as 0x0F+0x01 expose a half-carry taken from the wrong bit. Subtractions on both sides of equality expose an inverted borrow sense or a missing +1. Add-with-carry runs after the stored carry has been set and after it has been cleared, which catches a carry-in wired to a constant. Bitwise ops follow arithmetic ops that set C, H and V, so a design that cleared or overwrote C and H there fails. Reserved opcodes and writes with the enable low catch flags that update when they should hold.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_ADC  = 3'b001,
    OP_SUB  = 3'b010,
    OP_AND  = 3'b011,
    OP_OR   = 3'b100,
    OP_XOR  = 3'b101,
    OP_RSV6 = 3'b110,
    OP_RSV7 = 3'b111
  } opcode_e;

  typedef enum logic [2:0] {
    PICK_SUM,
    PICK_AND,
    PICK_OR,
    PICK_XOR,
    PICK_ZERO
  } pick_e;

  // strobes from control to datapath
  typedef struct packed {
    logic  invertB;
    logic  carryOne;
    logic  carryFromFlag;
    pick_e pick;
    logic  wrArith;
    logic  wrLogic;
  } strobe_t;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
    logic h;
  } flags_t;

endpackage

// File: rtl/alu_flag_ctrl.sv
module alu_flag_ctrl
  import alu_flag_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] opcode,
  input  logic       flagWe,
  output strobe_t    strobe
);

  opcode_e opSel;
  assign opSel = opcode_e'(opcode);

  always_comb begin
    strobe      = '0;
    strobe.pick = PICK_ZERO;
    case (opSel)
      OP_ADD: begin
        strobe.pick    = PICK_SUM;
        strobe.wrArith = flagWe;
      end
      OP_ADC: begin
        strobe.pick          = PICK_SUM;
        strobe.carryFromFlag = 1'b1;
        strobe.wrArith       = flagWe;
      end
      OP_SUB: begin
        strobe.pick     = PICK_SUM;
        strobe.invertB  = 1'b1;
        strobe.carryOne = 1'b1;
        strobe.wrArith  = flagWe;
      end
      OP_AND: begin
        strobe.pick    = PICK_AND;
        strobe.wrLogic = flagWe;
      end
      OP_OR: begin
        strobe.pick    = PICK_OR;
        strobe.wrLogic = flagWe;
      end
      OP_XOR: begin
        strobe.pick    = PICK_XOR;
        strobe.wrLogic = flagWe;
      end
      default: begin
        strobe.pick = PICK_ZERO;
      end
    endcase
  end

  // R11: no flag write strobe without the enable
  a_r11_no_write_without_enable: assert property (@(posedge clk) disable iff (!rstN)
    !flagWe |-> !(strobe.wrArith || strobe.wrLogic));

  // R5: reserved codes never raise a write strobe
  a_r5_reserved_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (opcode[2:1] == 2'b11) |-> !(strobe.wrArith || strobe.wrLogic));

  a_r10_single_write_kind: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrArith, strobe.wrLogic}));

endmodule

// File: rtl/alu_flag_datapath.sv
module alu_flag_datapath
  import alu_flag_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  strobe_t          strobe,
  output logic [WIDTH-1:0] result,
  output flags_t           flagQ
);

  localparam int HalfIdx = WIDTH / 2;   // carry into the upper half
  localparam int MsbIdx  = WIDTH - 1;

  logic [WIDTH-1:0] bMux;
  logic [WIDTH-1:0] sumVec;
  logic [WIDTH:0]   carryVec;
  flags_t           flagD;

  // conditional inversion array for subtraction
  assign bMux        = opB ^ {WIDTH{strobe.invertB}};
  assign carryVec[0] = strobe.carryOne | (strobe.carryFromFlag & flagQ.c);

  // ripple-carry chain
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sumVec[i]     = opA[i] ^ bMux[i] ^ carryVec[i];
    assign carryVec[i+1] = (opA[i] & bMux[i]) | (carryVec[i] & (opA[i] ^ bMux[i]));
  end

  // all units in parallel, opcode picks
  always_comb begin
    case (strobe.pick)
      PICK_SUM: result = sumVec;
      PICK_AND: result = opA & opB;
      PICK_OR:  result = opA | opB;
      PICK_XOR: result = opA ^ opB;
      default:  result = '0;
    endcase
  end

  always_comb begin
    flagD.c = carryVec[WIDTH];
    flagD.z = ~|result;
    flagD.n = result[MsbIdx];
    flagD.v = carryVec[WIDTH] ^ carryVec[MsbIdx];
    flagD.h = carryVec[HalfIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= '0;
    end else if (strobe.wrArith) begin
      flagQ <= flagD;
    end else if (strobe.wrLogic) begin
      flagQ.z <= flagD.z;
      flagQ.n <= flagD.n;
      flagQ.v <= 1'b0;
    end
  end

  // R11: flags hold when nothing writes them
  a_r11_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrArith || strobe.wrLogic) |=> $stable(flagQ));

  // R10: bitwise write keeps C and H, clears V
  a_r10_logic_keeps_ch: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrLogic |=> (flagQ.c == $past(flagQ.c)) && (flagQ.h == $past(flagQ.h)) && !flagQ.v);

  // R8: overflow matches the sign rule on the adder inputs and output
  a_r8_signed_overflow: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrArith |=> flagQ.v == (($past(opA[MsbIdx]) == $past(bMux[MsbIdx])) &&
                                   ($past(result[MsbIdx]) != $past(opA[MsbIdx]))));

  // R7: zero and negative track the written result
  a_r7_zero_negative: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrArith || strobe.wrLogic) |=>
      (flagQ.z == ($past(result) == '0)) && (flagQ.n == $past(result[MsbIdx])));

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       opcode,
  input  logic             flagWe,
  output logic [WIDTH-1:0] result,
  output logic             flagC,
  output logic             flagZ,
  output logic             flagN,
  output logic             flagV,
  output logic             flagH
);

  strobe_t strobe;
  flags_t  flagQ;

  alu_flag_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .opcode (opcode),
    .flagWe (flagWe),
    .strobe (strobe)
  );

  alu_flag_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .opA    (opA),
    .opB    (opB),
    .strobe (strobe),
    .result (result),
    .flagQ  (flagQ)
  );

  assign flagC = flagQ.c;
  assign flagZ = flagQ.z;
  assign flagN = flagQ.n;
  assign flagV = flagQ.v;
  assign flagH = flagQ.h;

  // R5: reserved opcodes give zero and leave the flags alone
  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (opcode[2:1] == 2'b11) |-> (result == '0));

  a_r5_reserved_hold: assert property (@(posedge clk) disable iff (!rstN)
    (opcode[2:1] == 2'b11) |=> $stable({flagC, flagZ, flagN, flagV, flagH}));

endmodule

// File: tb/alu_flag_unit_tb.sv
module alu_flag_unit_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] opA = '0;
  logic [7:0] opB = '0;
  logic [2:0] opcode = '0;
  logic       flagWe = 1'b0;
  logic [7:0] result;
  logic       flagC, flagZ, flagN, flagV, flagH;

  int nRun  = 0;
  int nFail = 0;
  bit done  = 1'b0;

  // model flags packed as {C,Z,N,V,H}
  logic [4:0] mFlags = '0;

  always #5 clk = ~clk;

  alu_flag_unit u_dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opcode(opcode), .flagWe(flagWe),
    .result(result), .flagC(flagC), .flagZ(flagZ), .flagN(flagN), .flagV(flagV), .flagH(flagH)
  );

  function automatic logic [4:0] dutFlags();
    return {flagC, flagZ, flagN, flagV, flagH};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one op, check the result then the flags after the edge
  task automatic doOp(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                      input logic we, input string tag);
    logic [7:0] bx, expRes;
    logic       cin, c7, c6, h;
    logic [8:0] full;
    logic [7:0] low7;
    logic [4:0] low4;
    logic [4:0] nxt;
    bx  = (op == 3'b010) ? ~b : b;
    cin = (op == 3'b010) ? 1'b1 : (op == 3'b001) ? mFlags[4] : 1'b0;
    full = {1'b0, a} + {1'b0, bx} + {8'd0, cin};
    low7 = {1'b0, a[6:0]} + {1'b0, bx[6:0]} + {7'd0, cin};
    low4 = {1'b0, a[3:0]} + {1'b0, bx[3:0]} + {4'd0, cin};
    c7 = full[8]; c6 = low7[7]; h = low4[4];
    case (op)
      3'b000, 3'b001, 3'b010: expRes = full[7:0];
      3'b011: expRes = a & b;
      3'b100: expRes = a | b;
      3'b101: expRes = a ^ b;
      default: expRes = 8'h00;
    endcase
    nxt = mFlags;
    if (we) begin
      if (op <= 3'b010)
        nxt = {c7, expRes == 8'h00, expRes[7], c6 ^ c7, h};
      else if (op <= 3'b101)
        nxt = {mFlags[4], expRes == 8'h00, expRes[7], 1'b0, mFlags[0]};
    end
    @(negedge clk);
    opcode = op; opA = a; opB = b; flagWe = we;
    #1;
    check({tag, " result"}, result, expRes);
    @(posedge clk);
    #1;
    check({tag, " flags CZNVH"}, {3'b000, dutFlags()}, {3'b000, nxt});
    mFlags = nxt;
    @(negedge clk);
    flagWe = 1'b0;
  endtask

  task automatic tReset();
    @(negedge clk);
    rstN = 1'b0; flagWe = 1'b1; opcode = 3'b000; opA = 8'hFF; opB = 8'h01;
    @(posedge clk);
    #1;
    check("R12 flags cleared by reset", {3'b000, dutFlags()}, 8'h00);
    mFlags = '0;
    @(negedge clk);
    rstN = 1'b1; flagWe = 1'b0;
  endtask

  task automatic tAdd();
    doOp(3'b000, 8'h12, 8'h34, 1'b1, "R1 add plain");
    doOp(3'b000, 8'h0F, 8'h01, 1'b1, "R9 add half carry");
    doOp(3'b000, 8'h7F, 8'h01, 1'b1, "R8 add overflow without carry");
    doOp(3'b000, 8'hFF, 8'h01, 1'b1, "R6 add carry without overflow, R7 zero");
    doOp(3'b000, 8'h80, 8'h80, 1'b1, "R8 R6 add carry and overflow");
  endtask

  task automatic tAdc();
    doOp(3'b000, 8'hFF, 8'h01, 1'b1, "R2 set carry");
    doOp(3'b001, 8'h10, 8'h20, 1'b1, "R2 adc with carry set");
    doOp(3'b001, 8'h10, 8'h20, 1'b1, "R2 adc with carry clear");
  endtask

  task automatic tSub();
    doOp(3'b010, 8'h05, 8'h03, 1'b1, "R3 sub no borrow");
    doOp(3'b010, 8'h03, 8'h05, 1'b1, "R3 sub borrow, R7 negative");
    doOp(3'b010, 8'h80, 8'h01, 1'b1, "R8 sub signed overflow");
    doOp(3'b010, 8'h5A, 8'h5A, 1'b1, "R3 sub equal, R7 zero");
  endtask

  task automatic tLogic();
    doOp(3'b000, 8'h88, 8'h88, 1'b1, "R10 prime C H V");
    doOp(3'b011, 8'hF0, 8'h3C, 1'b1, "R4 and, R10 keep C H");
    doOp(3'b000, 8'h8F, 8'h81, 1'b1, "R10 prime again");
    doOp(3'b100, 8'h80, 8'h01, 1'b1, "R4 or, R10 clear V");
    doOp(3'b101, 8'hA5, 8'hA5, 1'b1, "R4 xor, R7 zero");
  endtask

  task automatic tReserved();
    doOp(3'b000, 8'h80, 8'h80, 1'b1, "R5 prime flags");
    doOp(3'b110, 8'h12, 8'h34, 1'b1, "R5 code 110 ignored");
    doOp(3'b111, 8'h00, 8'h00, 1'b1, "R5 code 111 ignored");
  endtask

  task automatic tNoWrite();
    doOp(3'b000, 8'h01, 8'h01, 1'b1, "R11 prime flags");
    doOp(3'b000, 8'hFF, 8'h01, 1'b0, "R11 add without enable");
    doOp(3'b011, 8'h00, 8'h00, 1'b0, "R11 and without enable");
  endtask

  task automatic tMidReset();
    doOp(3'b000, 8'h80, 8'h80, 1'b1, "R12 prime flags");
    tReset();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    tReset();
    tAdd();
    tAdc();
    tSub();
    tLogic();
    tReserved();
    tNoWrite();
    tMidReset();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule